// File: doc/BRIEF.md
# 8-bit Accumulator Execution Unit with Status Flags

This block is the data-path execution unit of a small accumulator-style processor. It owns the accumulator (A), two index registers (X and Y) and an 8-bit processor status byte. Every clock cycle it takes one command: a two-bit kind field, a 6-bit operation code and an 8-bit memory operand. Depending on the kind, it runs the operation, holds its state, or returns to its initial state.

All outputs are registered. The result byte, the status byte, X, Y and a one-cycle illegal-operation flag all reflect the command presented on the previous cycle. Address generation, branching, stack pointer handling, instruction fetch and decimal-mode arithmetic are handled outside this unit. Add and subtract here are always binary, whatever the D flag holds.

The accumulator has no port of its own. It shows on the result output after a store or push operation, and after every operation that writes it.

Top module: `acc_alu`

## Requirements
- R1: On rst_n low, or a command of kind 2 (init), A, X, Y and result_o become 0, status_o becomes 8'h22 and illegal_o becomes 0. Status bits: C=0, Z=1, I=2, D=3, B=4, constant one=5, V=6, N=7.
- R2: Kind 1 executes op_i. Kinds 0 and 3 leave every output and every internal register unchanged. Outputs change at the clock edge that samples the command, so they show it one cycle later.
- R3: Operation codes are: 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6/7 shift-left A/M, 8/9 shift-right A/M, 10/11 rotate-left A/M, 12/13 rotate-right A/M, 14/15 increment/decrement M, 16/17 increment X/Y, 18/19 decrement X/Y, 20/21/22 compare A/X/Y, 23 bit test, 24/25/26 load A/X/Y, 27 store A, 28 push A, 29 pull A, 30 pull status, 31 interrupt-return status, 32/33 clear/set C, 34/35 clear/set D, 36/37 clear/set I, 38 clear V, 39 break. The no-op changes nothing.
- R4: Add computes A+M+C into A and result_o. C is set when the true sum exceeds 255. V is set when A and M share bit 7 and the result's bit 7 differs. Z marks a zero result and N copies bit 7.
- R5: Subtract computes A-M-1+C into A and result_o. C becomes the inverse of result bit 7. V, Z and N follow the add rules, using the same operands.
- R6: And/or/xor/load-A/pull-A write A and result_o and set Z and N. Load X/Y write only that register plus Z and N. Store and push copy A to result_o and leave status unchanged.
- R7: Shift-left moves bit 7 into C and fills bit 0 with zero. Shift-right moves bit 0 into C and fills bit 7 with zero. Rotates shift the old C into the vacated bit and the outgoing bit into C. The A variants write A and result_o. The M variants write only result_o. Z and N follow the new value.
- R8: Increment/decrement M drive M±1 on result_o with Z and N. Increment/decrement X or Y change only that register plus Z and N, and result_o stays unchanged.
- R9: Compare sets Z and N from (register - M) modulo 256 and sets C when the register is unsigned at least M. No register and no result is written.
- R10: Bit test sets Z when A&M is zero, copies M bit 7 into N and M bit 6 into V, and leaves C, A and result_o unchanged.
- R11: Pull status and interrupt-return load the status byte from M with bit 5 forced to one. Break sets bit 4. The set/clear codes change only their own flag.
- R12: Status bit 5 reads one at every cycle after reset.
- R13: Kind 1 with an opcode of 40 to 63 changes no state and raises illegal_o for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| kind_i | input | 2 | Command kind: 0 hold, 1 execute, 2 init, 3 hold |
| op_i | input | 6 | Operation code |
| mem_i | input | 8 | Memory operand M |
| result_o | output | 8 | Registered result byte |
| status_o | output | 8 | Registered status byte |
| x_o | output | 8 | X register |
| y_o | output | 8 | Y register |
| illegal_o | output | 1 | One-cycle flag for an undefined opcode |

## Verification
The hardest states to reach from the ports are the signed-overflow cases of add and subtract and the rotates that run through a set carry. Both need A and C prepared by earlier commands, because A has no port and C only changes as a side effect. Directed sequences first load A, set or clear C, and then apply the boundary operands, such as 0x7F+1, 0xFF plus a carry, and a borrow that flips the sign. A long seeded random run then mixes every kind and opcode, including undefined codes. That stream keeps the hidden accumulator in varied states, which store and push operations expose on result_o.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W      = 6;
    localparam int NUM_LEGAL = 40;

    // status bit positions
    localparam int ST_C   = 0;
    localparam int ST_Z   = 1;
    localparam int ST_I   = 2;
    localparam int ST_D   = 3;
    localparam int ST_B   = 4;
    localparam int ST_ONE = 5;
    localparam int ST_V   = 6;
    localparam int ST_N   = 7;
    localparam logic [7:0] ST_INIT = 8'h22;

    localparam logic [1:0] KIND_HOLD  = 2'd0;
    localparam logic [1:0] KIND_RUN   = 2'd1;
    localparam logic [1:0] KIND_INIT  = 2'd2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 6'd0,  OP_ADC  = 6'd1,  OP_SBC  = 6'd2,  OP_AND  = 6'd3,
        OP_ORA  = 6'd4,  OP_EOR  = 6'd5,  OP_SLA  = 6'd6,  OP_SLM  = 6'd7,
        OP_SRA  = 6'd8,  OP_SRM  = 6'd9,  OP_RLA  = 6'd10, OP_RLM  = 6'd11,
        OP_RRA  = 6'd12, OP_RRM  = 6'd13, OP_INCM = 6'd14, OP_DECM = 6'd15,
        OP_INX  = 6'd16, OP_INY  = 6'd17, OP_DEX  = 6'd18, OP_DEY  = 6'd19,
        OP_CMPA = 6'd20, OP_CMPX = 6'd21, OP_CMPY = 6'd22, OP_BIT  = 6'd23,
        OP_LDA  = 6'd24, OP_LDX  = 6'd25, OP_LDY  = 6'd26, OP_STA  = 6'd27,
        OP_PHA  = 6'd28, OP_PLA  = 6'd29, OP_PLS  = 6'd30, OP_RTI  = 6'd31,
        OP_CLC  = 6'd32, OP_SEC  = 6'd33, OP_CLD  = 6'd34, OP_SED  = 6'd35,
        OP_CLI  = 6'd36, OP_SEI  = 6'd37, OP_CLV  = 6'd38, OP_BRK  = 6'd39
    } op_e;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] code_i,
    output op_e             op_o,
    output logic            legal_o
);
    always_comb begin
        legal_o = (int'(code_i) < NUM_LEGAL);
        op_o    = legal_o ? op_e'(code_i) : OP_NOP;
    end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op_i,
    input  logic [DW-1:0] m_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic [7:0]    p_i,
    input  logic [DW-1:0] r_i,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] y_o,
    output logic [7:0]    p_o,
    output logic [DW-1:0] r_o
);
    localparam int MSB = DW - 1;

    logic [DW:0]   sum;
    logic [DW-1:0] dif;
    logic [DW-1:0] cmp_src;
    logic [DW-1:0] zn_val;
    logic          zn_upd;
    logic          cin;

    always_comb begin
        a_o = a_i; x_o = x_i; y_o = y_i; p_o = p_i; r_o = r_i;
        cin     = p_i[ST_C];
        sum     = {1'b0, a_i} + {1'b0, m_i} + {{DW{1'b0}}, cin};
        dif     = a_i + ~m_i + {{(DW-1){1'b0}}, cin};
        cmp_src = (op_i == OP_CMPX) ? x_i : (op_i == OP_CMPY) ? y_i : a_i;
        zn_val  = '0;
        zn_upd  = 1'b0;
        unique case (op_i)
            OP_ADC: begin
                a_o = sum[MSB:0]; r_o = sum[MSB:0];
                p_o[ST_C] = sum[DW];
                p_o[ST_V] = (a_i[MSB] == m_i[MSB]) && (sum[MSB] != a_i[MSB]);
                zn_val = sum[MSB:0]; zn_upd = 1'b1;
            end
            OP_SBC: begin
                a_o = dif; r_o = dif;
                p_o[ST_C] = ~dif[MSB];
                p_o[ST_V] = (a_i[MSB] == m_i[MSB]) && (dif[MSB] != a_i[MSB]);
                zn_val = dif; zn_upd = 1'b1;
            end
            OP_AND: begin a_o = a_i & m_i; r_o = a_o; zn_val = a_o; zn_upd = 1'b1; end
            OP_ORA: begin a_o = a_i | m_i; r_o = a_o; zn_val = a_o; zn_upd = 1'b1; end
            OP_EOR: begin a_o = a_i ^ m_i; r_o = a_o; zn_val = a_o; zn_upd = 1'b1; end
            OP_SLA: begin
                p_o[ST_C] = a_i[MSB]; a_o = {a_i[MSB-1:0], 1'b0};
                r_o = a_o; zn_val = a_o; zn_upd = 1'b1;
            end
            OP_SLM: begin
                p_o[ST_C] = m_i[MSB]; r_o = {m_i[MSB-1:0], 1'b0};
                zn_val = r_o; zn_upd = 1'b1;
            end
            OP_SRA: begin
                p_o[ST_C] = a_i[0]; a_o = {1'b0, a_i[MSB:1]};
                r_o = a_o; zn_val = a_o; zn_upd = 1'b1;
            end
            OP_SRM: begin
                p_o[ST_C] = m_i[0]; r_o = {1'b0, m_i[MSB:1]};
                zn_val = r_o; zn_upd = 1'b1;
            end
            OP_RLA: begin
                p_o[ST_C] = a_i[MSB]; a_o = {a_i[MSB-1:0], cin};
                r_o = a_o; zn_val = a_o; zn_upd = 1'b1;
            end
            OP_RLM: begin
                p_o[ST_C] = m_i[MSB]; r_o = {m_i[MSB-1:0], cin};
                zn_val = r_o; zn_upd = 1'b1;
            end
            OP_RRA: begin
                p_o[ST_C] = a_i[0]; a_o = {cin, a_i[MSB:1]};
                r_o = a_o; zn_val = a_o; zn_upd = 1'b1;
            end
            OP_RRM: begin
                p_o[ST_C] = m_i[0]; r_o = {cin, m_i[MSB:1]};
                zn_val = r_o; zn_upd = 1'b1;
            end
            OP_INCM: begin r_o = m_i + 1'b1; zn_val = r_o; zn_upd = 1'b1; end
            OP_DECM: begin r_o = m_i - 1'b1; zn_val = r_o; zn_upd = 1'b1; end
            OP_INX:  begin x_o = x_i + 1'b1; zn_val = x_o; zn_upd = 1'b1; end
            OP_INY:  begin y_o = y_i + 1'b1; zn_val = y_o; zn_upd = 1'b1; end
            OP_DEX:  begin x_o = x_i - 1'b1; zn_val = x_o; zn_upd = 1'b1; end
            OP_DEY:  begin y_o = y_i - 1'b1; zn_val = y_o; zn_upd = 1'b1; end
            OP_CMPA, OP_CMPX, OP_CMPY: begin
                zn_val = cmp_src - m_i; zn_upd = 1'b1;
                p_o[ST_C] = (cmp_src >= m_i);
            end
            OP_BIT: begin
                p_o[ST_Z] = ((a_i & m_i) == '0);
                p_o[ST_N] = m_i[MSB];
                p_o[ST_V] = m_i[MSB-1];
            end
            OP_LDA, OP_PLA: begin a_o = m_i; r_o = m_i; zn_val = m_i; zn_upd = 1'b1; end
            OP_LDX: begin x_o = m_i; zn_val = m_i; zn_upd = 1'b1; end
            OP_LDY: begin y_o = m_i; zn_val = m_i; zn_upd = 1'b1; end
            OP_STA, OP_PHA: r_o = a_i;
            OP_PLS, OP_RTI: begin
                p_o = m_i[7:0];
                p_o[ST_ONE] = 1'b1;
            end
            OP_CLC: p_o[ST_C] = 1'b0;
            OP_SEC: p_o[ST_C] = 1'b1;
            OP_CLD: p_o[ST_D] = 1'b0;
            OP_SED: p_o[ST_D] = 1'b1;
            OP_CLI: p_o[ST_I] = 1'b0;
            OP_SEI: p_o[ST_I] = 1'b1;
            OP_CLV: p_o[ST_V] = 1'b0;
            OP_BRK: p_o[ST_B] = 1'b1;
            default: ;
        endcase
        if (zn_upd) begin
            p_o[ST_Z] = (zn_val == '0);
            p_o[ST_N] = zn_val[MSB];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      kind_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [DW-1:0]   mem_i,
    output logic [DW-1:0]   result_o,
    output logic [7:0]      status_o,
    output logic [DW-1:0]   x_o,
    output logic [DW-1:0]   y_o,
    output logic            illegal_o
);
    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [DW-1:0] res;
        logic [7:0]    p;
        logic          ill;
    } state_t;

    state_t st_d, st_q, st_init;

    op_e           op_dec;
    logic          legal;
    logic [DW-1:0] a_x, x_x, y_x, r_x;
    logic [7:0]    p_x;

    acc_alu_decode u_dec (
        .code_i (op_i),
        .op_o   (op_dec),
        .legal_o(legal)
    );

    acc_alu_exec #(.DW(DW)) u_exec (
        .op_i(op_dec), .m_i(mem_i),
        .a_i(st_q.a), .x_i(st_q.x), .y_i(st_q.y), .p_i(st_q.p), .r_i(st_q.res),
        .a_o(a_x), .x_o(x_x), .y_o(y_x), .p_o(p_x), .r_o(r_x)
    );

    always_comb begin
        st_init = '{a: '0, x: '0, y: '0, res: '0, p: ST_INIT, ill: 1'b0};
        st_d     = st_q;
        st_d.ill = 1'b0;
        case (kind_i)
            KIND_RUN: begin
                if (legal) begin
                    st_d.a = a_x; st_d.x = x_x; st_d.y = y_x;
                    st_d.p = p_x; st_d.res = r_x;
                end else begin
                    st_d.ill = 1'b1;
                end
            end
            KIND_INIT: st_d = st_init;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_init;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.res;
    assign status_o  = st_q.p;
    assign x_o       = st_q.x;
    assign y_o       = st_q.y;
    assign illegal_o = st_q.ill;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      kind_i,
    input logic [OP_W-1:0] op_i,
    input logic [DW-1:0]   result_o,
    input logic [7:0]      status_o,
    input logic [DW-1:0]   x_o,
    input logic [DW-1:0]   y_o,
    input logic            illegal_o
);
    logic run_c;
    assign run_c = (kind_i == KIND_RUN);

    assert_bit5_R12: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[ST_ONE] == 1'b1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 2'd0 || kind_i == 2'd3) |=>
        ($stable(result_o) && $stable(status_o) && $stable(x_o) && $stable(y_o) && !illegal_o));

    assert_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_INIT) |=>
        (result_o == '0 && x_o == '0 && y_o == '0 && status_o == ST_INIT && !illegal_o));

    assert_illegal_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (run_c && int'(op_i) >= NUM_LEGAL) |=>
        (illegal_o && $stable(result_o) && $stable(status_o) && $stable(x_o) && $stable(y_o)));

    assert_illegal_src_R13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($past(kind_i) == KIND_RUN && int'($past(op_i)) >= NUM_LEGAL));

    assert_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_c && (op_i == OP_CMPA || op_i == OP_CMPX || op_i == OP_CMPY)) |=>
        ($stable(result_o) && $stable(x_o) && $stable(y_o)));

    assert_inx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_c && op_i == OP_INX) |=>
        (x_o == DW'($past(x_o) + 1'b1) && $stable(result_o) && $stable(y_o)));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .op_i(op_i),
    .result_o(result_o), .status_o(status_o), .x_o(x_o), .y_o(y_o),
    .illegal_o(illegal_o)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] kind_i = 2'd0;
    logic [5:0] op_i = 6'd0;
    logic [7:0] mem_i = 8'd0;
    logic [7:0] result_o, status_o, x_o, y_o;
    logic       illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [7:0] ma, mx, my, mp, mr;
    logic       mill;

    always #5 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .op_i(op_i), .mem_i(mem_i),
        .result_o(result_o), .status_o(status_o), .x_o(x_o), .y_o(y_o),
        .illegal_o(illegal_o)
    );

    task automatic m_init();
        ma = 0; mx = 0; my = 0; mr = 0; mp = 8'h22; mill = 0;
    endtask

    task automatic zn(input logic [7:0] v);
        mp[1] = (v == 8'h00);
        mp[7] = v[7];
    endtask

    task automatic model(input logic [1:0] k, input logic [5:0] op, input logic [7:0] m);
        int s;
        logic [7:0] t, src;
        logic c;
        mill = 0;
        c = mp[0];
        if (k == 2'd2) begin
            m_init();
        end else if (k == 2'd1) begin
            if (op >= 6'd40) mill = 1;
            else case (op)
                1: begin s = int'(ma) + int'(m) + int'(c); t = s[7:0];
                         mp[0] = (s > 255); mp[6] = (ma[7] == m[7]) && (t[7] != ma[7]);
                         ma = t; mr = t; zn(t); end
                2: begin s = int'(ma) - int'(m) - 1 + int'(c); t = s[7:0];
                         mp[0] = !t[7]; mp[6] = (ma[7] == m[7]) && (t[7] != ma[7]);
                         ma = t; mr = t; zn(t); end
                3: begin ma = ma & m; mr = ma; zn(ma); end
                4: begin ma = ma | m; mr = ma; zn(ma); end
                5: begin ma = ma ^ m; mr = ma; zn(ma); end
                6: begin mp[0] = ma[7]; ma = ma << 1; mr = ma; zn(ma); end
                7: begin mp[0] = m[7]; mr = m << 1; zn(mr); end
                8: begin mp[0] = ma[0]; ma = ma >> 1; mr = ma; zn(ma); end
                9: begin mp[0] = m[0]; mr = m >> 1; zn(mr); end
                10: begin mp[0] = ma[7]; ma = (ma << 1) | {7'd0, c}; mr = ma; zn(ma); end
                11: begin mp[0] = m[7]; mr = (m << 1) | {7'd0, c}; zn(mr); end
                12: begin mp[0] = ma[0]; ma = (ma >> 1) | {c, 7'd0}; mr = ma; zn(ma); end
                13: begin mp[0] = m[0]; mr = (m >> 1) | {c, 7'd0}; zn(mr); end
                14: begin mr = m + 8'd1; zn(mr); end
                15: begin mr = m - 8'd1; zn(mr); end
                16: begin mx = mx + 8'd1; zn(mx); end
                17: begin my = my + 8'd1; zn(my); end
                18: begin mx = mx - 8'd1; zn(mx); end
                19: begin my = my - 8'd1; zn(my); end
                20, 21, 22: begin
                    src = (op == 20) ? ma : (op == 21) ? mx : my;
                    zn(src - m); mp[0] = (src >= m); end
                23: begin mp[1] = ((ma & m) == 0); mp[7] = m[7]; mp[6] = m[6]; end
                24, 29: begin ma = m; mr = m; zn(m); end
                25: begin mx = m; zn(m); end
                26: begin my = m; zn(m); end
                27, 28: mr = ma;
                30, 31: mp = m | 8'h20;
                32: mp[0] = 0; 33: mp[0] = 1;
                34: mp[3] = 0; 35: mp[3] = 1;
                36: mp[2] = 0; 37: mp[2] = 1;
                38: mp[6] = 0;
                39: mp[4] = 1;
                default: ;
            endcase
        end
    endtask

    function automatic string tag_of(input logic [1:0] k, input logic [5:0] op);
        if (k == 2'd2) return "R1";
        if (k != 2'd1) return "R2";
        if (op >= 6'd40) return "R13";
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4, 5, 24, 25, 26, 27, 28, 29: return "R6";
            6, 7, 8, 9, 10, 11, 12, 13: return "R7";
            14, 15, 16, 17, 18, 19: return "R8";
            20, 21, 22: return "R9";
            23: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (result_o !== mr || status_o !== mp || x_o !== mx || y_o !== my || illegal_o !== mill) begin
            fails++;
            $display("FAIL %s: got r=%h p=%h x=%h y=%h ill=%b exp r=%h p=%h x=%h y=%h ill=%b",
                     tag, result_o, status_o, x_o, y_o, illegal_o, mr, mp, mx, my, mill);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [5:0] op, input logic [7:0] m,
                        input string tag = "");
        @(negedge clk);
        kind_i = k; op_i = op; mem_i = m;
        model(k, op, m);
        @(posedge clk);
        #2;
        compare(tag == "" ? tag_of(k, op) : tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_init();
        repeat (3) @(posedge clk);
        #2;
        compare("R1");                       // R1 reset state
        @(negedge clk) rst_n = 1'b1;

        // R4 signed overflow 0x7F + 1
        step(1, 24, 8'h7F); step(1, 32, 0); step(1, 1, 8'h01, "R4");
        // R4 carry out 0xFF + 0 + C
        step(1, 33, 0); step(1, 24, 8'hFF); step(1, 1, 8'h00, "R4");
        // R5 borrow with sign flip
        step(1, 32, 0); step(1, 24, 8'h10); step(1, 2, 8'h20, "R5");
        // R9 equal compare, then store exposes A unchanged
        step(1, 24, 8'h42); step(1, 20, 8'h42, "R9"); step(1, 27, 0, "R9");
        // R8 index wrap
        step(1, 25, 8'hFF); step(1, 16, 0, "R8"); step(1, 19, 0, "R8");
        // R7 rotate through a set carry
        step(1, 33, 0); step(1, 24, 8'h80); step(1, 10, 0, "R7"); step(1, 13, 8'h01, "R7");
        // R12 pull status of zero keeps bit 5
        step(1, 30, 8'h00, "R12");
        step(1, 31, 8'hDF, "R11");
        // R10 bit test
        step(1, 24, 8'h01); step(1, 23, 8'hC0, "R10");
        // R13 undefined opcode then R2 hold
        step(1, 63, 8'h55, "R13"); step(1, 40, 8'hAA, "R13");
        step(0, 1, 8'h77, "R2"); step(3, 24, 8'h00, "R2");
        step(1, 0, 8'h12, "R3");
        step(2, 0, 0, "R1");

        // seeded random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [1:0] k;
            logic [5:0] op;
            r = $urandom_range(0, 99);
            k = (r < 84) ? 2'd1 : (r < 92) ? 2'd0 : (r < 98) ? 2'd3 : 2'd2;
            op = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(40, 63))
                                             : 6'($urandom_range(0, 39));
            step(k, op, 8'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule